// File: doc/BRIEF.md
# Token Register Cell

This block holds one architectural register value for a dataflow machine that has no central register file. The value lives as a single token in a small queue. Any number of consumers can copy the token from the read outbox without removing it. A producer delivers a new value through the write inbox, which has a valid/ready handshake. The cell enqueues the new token and, one cycle later, retires the old one, so the cell again holds exactly one value. It then raises a one-cycle done pulse, which the instruction sequencer uses to release the next instruction.

The read outbox is withdrawn while a write is in flight, so no reader can catch the cell holding two tokens. A build-time option turns the cell into a hard-wired zero register. That variant still completes the write handshake and pulses done, but it never changes its value.

Top module: `tok_reg_cell`

## Requirements
- R1: Coming out of reset, rd_valid_o is 1, rd_data_o is 0, wr_ready_o is 1 and wr_done_o is 0.
- R2: Reads are copies. While no write is accepted, rd_valid_o stays 1 and rd_data_o keeps its value, whatever rd_ready_i does.
- R3: A write is accepted on a rising edge where wr_valid_i and wr_ready_o are both 1. From the second rising edge after it (counting the accepting edge as the first), rd_data_o shows the written value.
- R4: In the cycle after an accepting edge, rd_valid_o and wr_ready_o are both 0. Both return to 1 after the next edge.
- R5: wr_done_o is 1 for exactly one cycle: the cycle following the second edge of each write. It is 0 at all other times.
- R6: The internal queue never holds fewer than one or more than two tokens. A new token is added only when exactly one is present, and one is removed only when two are present.
- R7: If wr_valid_i is held high continuously, one write is accepted every two cycles. The values appear on rd_data_o in the order they were offered, each followed by its own done pulse.
- R8: When wr_valid_i is 0, wr_data_i has no effect on rd_data_o.
- R9: With ZERO_REG=1, rd_data_o is always 0. Writes are still accepted with the same ready timing and the same done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write inbox offers a value |
| wr_ready_o | output | 1 | Cell can take a write |
| wr_data_i | input | DATA_W | Value to write |
| wr_done_o | output | 1 | One-cycle pulse when a write has finished |
| rd_valid_o | output | 1 | Read outbox holds a stable token |
| rd_ready_i | input | 1 | Reader copies the token (not consumed) |
| rd_data_o | output | DATA_W | Current register value |

## Verification
The bench polls the read side repeatedly with rd_ready_i high. A cell that treated reads as consuming would lose its token and drop rd_valid_o. During the retire cycle the bench checks that both ready signals are low. A design that exposed the queue head early would show the old value with valid high, and one that took a second write too soon would overflow the two-entry queue. Holding wr_valid_i high across back-to-back writes catches a write taken during retire and a done pulse that is stretched or merged. A second instance with ZERO_REG=1 checks that writes are acknowledged but never alter the zero value.

// File: rtl/tok_reg_pkg.sv
package tok_reg_pkg;
  localparam int unsigned DEPTH = 2;
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic {
    WS_IDLE   = 1'b0,
    WS_RETIRE = 1'b1
  } wr_state_e;
endpackage

// File: rtl/tok_queue.sv
module tok_queue
  import tok_reg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output cnt_t              count_o
);
  localparam cnt_t CNT_ONE = cnt_t'(1);
  localparam cnt_t CNT_MAX = cnt_t'(DEPTH);

  logic [DATA_W-1:0] slot_q [DEPTH];
  ptr_t rd_ptr_q, wr_ptr_q;
  cnt_t count_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             slot_q[i] <= '0;
      else if (push_i && wr_ptr_q == ptr_t'(i)) slot_q[i] <= push_data_i;
    end
  end

  // reset leaves one zero token at slot 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= ptr_t'(1);
      count_q  <= CNT_ONE;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + ptr_t'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + ptr_t'(1);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + CNT_ONE;
        2'b01:   count_q <= count_q - CNT_ONE;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = slot_q[rd_ptr_q];
  assign count_o = count_q;

  // R6
  occupancy_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q >= CNT_ONE && count_q <= CNT_MAX);
  // R6
  push_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> count_q == CNT_ONE);
  // R6
  pop_spare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q == CNT_MAX);
endmodule

// File: rtl/tok_wr_ctrl.sv
module tok_wr_ctrl
  import tok_reg_pkg::*;
#(
  parameter bit ZERO_REG = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_valid_i,
  output logic wr_ready_o,
  output logic accept_o,
  output logic push_o,
  output logic pop_o,
  output logic busy_o,
  output logic done_o
);
  wr_state_e state_q, state_d;
  logic done_q;

  assign wr_ready_o = (state_q == WS_IDLE);
  assign accept_o   = wr_valid_i && wr_ready_o;
  assign busy_o     = (state_q == WS_RETIRE);

  // zero register keeps the handshake but never touches the queue
  if (ZERO_REG) begin : g_zero
    assign push_o = 1'b0;
    assign pop_o  = 1'b0;
  end else begin : g_live
    assign push_o = accept_o;
    assign pop_o  = busy_o;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE:   if (accept_o) state_d = WS_RETIRE;
      WS_RETIRE: state_d = WS_IDLE;
      default:   state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= busy_o;
    end
  end

  assign done_o = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R5
  done_after_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> done_q);
  // R4
  retire_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o && !wr_ready_o);
  // R4
  retire_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> wr_ready_o);
endmodule

// File: rtl/tok_reg_cell.sv
module tok_reg_cell
  import tok_reg_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter bit          ZERO_REG = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_done_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic accept, push, pop, busy;
  cnt_t count;

  tok_wr_ctrl #(.ZERO_REG(ZERO_REG)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_ready_o (wr_ready_o),
    .accept_o   (accept),
    .push_o     (push),
    .pop_o      (pop),
    .busy_o     (busy),
    .done_o     (wr_done_o)
  );

  tok_queue #(.DATA_W(DATA_W)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .head_o      (rd_data_o),
    .count_o     (count)
  );

  // hide the outbox while two tokens may coexist
  assign rd_valid_o = !busy && (count == cnt_t'(1));

  // R4
  rd_hidden_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !rd_valid_o);
  // R2
  copy_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_ready_i && !accept) |=> rd_valid_o && $stable(rd_data_o));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !wr_valid_i) |=> $stable(rd_data_o));

  if (ZERO_REG) begin : g_zero_chk
    // R9
    zero_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o == '0);
  end
endmodule

// File: tb/sim_tok_reg_cell.sv
module sim_tok_reg_cell;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic          wr_valid, rd_ready;
  logic [DW-1:0] wr_data;
  logic          wr_ready0, wr_done0, rd_valid0;
  logic [DW-1:0] rd_data0;
  logic          wr_ready1, wr_done1, rd_valid1;
  logic [DW-1:0] rd_data1;

  int n_chk = 0;
  int n_bad = 0;

  tok_reg_cell #(.DATA_W(DW), .ZERO_REG(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready0),
    .wr_data_i(wr_data), .wr_done_o(wr_done0), .rd_valid_o(rd_valid0),
    .rd_ready_i(rd_ready), .rd_data_o(rd_data0));

  tok_reg_cell #(.DATA_W(DW), .ZERO_REG(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready1),
    .wr_data_i(wr_data), .wr_done_o(wr_done1), .rd_valid_o(rd_valid1),
    .rd_ready_i(rd_ready), .rd_data_o(rd_data1));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // step one edge, then sample 1 ns after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // packed view of the control outputs: {wr_ready, rd_valid, wr_done}
  function automatic logic [DW-1:0] ctl0();
    return DW'({wr_ready0, rd_valid0, wr_done0});
  endfunction
  function automatic logic [DW-1:0] ctl1();
    return DW'({wr_ready1, rd_valid1, wr_done1});
  endfunction

  task automatic t_reset();
    chk("R1 ctl", ctl0(), DW'(3'b110));
    chk("R1 data", rd_data0, '0);
    chk("R1 zero-reg data", rd_data1, '0);
  endtask

  task automatic t_copy_read();
    rd_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R2 valid", DW'(rd_valid0), 1);
      chk("R2 data", rd_data0, '0);
    end
    rd_ready = 1'b0;
  endtask

  task automatic t_single_write(input logic [DW-1:0] v);
    wr_valid = 1'b1; wr_data = v;
    step();                                     // accepting edge
    wr_valid = 1'b0; wr_data = ~v;
    chk("R4 retire ctl", ctl0(), DW'(3'b000));
    chk("R9 zero-reg retire ctl", ctl1(), DW'(3'b000));
    step();
    chk("R3 new value", rd_data0, v);
    chk("R5 done+ready+valid", ctl0(), DW'(3'b111));
    chk("R9 zero-reg done", ctl1(), DW'(3'b111));
    chk("R9 zero-reg data", rd_data1, '0);
    step();
    chk("R5 done drops", DW'(wr_done0), 0);
    chk("R5 zero-reg done drops", DW'(wr_done1), 0);
  endtask

  task automatic t_ignore_data(input logic [DW-1:0] prev);
    wr_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      wr_data = 32'h5A5A_0000 + DW'(i);
      step();
      chk("R8 data held", rd_data0, prev);
      chk("R8 no done", DW'(wr_done0), 0);
    end
  endtask

  task automatic t_back_to_back();
    wr_valid = 1'b1; wr_data = 32'h1111_2222;
    step();                                     // A accepted
    wr_data = 32'h3333_4444;                    // offered during retire
    chk("R7 retire blocks", DW'(wr_ready0), 0);
    step();
    chk("R7 first value", rd_data0, 32'h1111_2222);
    chk("R7 first done", DW'(wr_done0), 1);
    step();                                     // B accepted
    wr_valid = 1'b0;
    chk("R7 second retire", ctl0(), DW'(3'b000));
    chk("R6 head still first", rd_data0, 32'h1111_2222);
    step();
    chk("R7 second value", rd_data0, 32'h3333_4444);
    chk("R7 second done", ctl0(), DW'(3'b111));
    step();
    chk("R5 single pulse", DW'(wr_done0), 0);
  endtask

  initial begin
    wr_valid = 1'b0; rd_ready = 1'b0; wr_data = '0;
    #5 rst_ni = 1'b1;
    #1;
    t_reset();
    t_copy_read();
    t_single_write(32'hDEAD_BEEF);
    t_ignore_data(32'hDEAD_BEEF);
    t_back_to_back();
    t_single_write(32'h0000_0001);
    t_copy_read_after(32'h0000_0001);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic t_copy_read_after(input logic [DW-1:0] v);
    rd_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R2 copy after write", rd_data0, v);
      chk("R2 valid after write", DW'(rd_valid0), 1);
    end
    rd_ready = 1'b0;
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule